// File: doc/BRIEF.md
# Signed XOR duty-cycle phase detector

The block compares two square waves sampled on the same clock and reports their phase difference as a signed integer. The two inputs are combined with an exclusive-OR. Each XOR period runs from one XOR rising edge to the next. For each period the block counts the samples in which the XOR is high. It then signs that count according to which input rose first. The result feeds a frequency-correction path as the loop-filter term, so no analog smoothing is needed.

At each XOR rising edge the count of the period that just ended is registered to the output, and a one-cycle strobe is raised. The counter then restarts. With a signal period of P samples and input A leading by d samples, the output is +d. The magnitude grows linearly up to half a period. Past that point the output wraps to the opposite sign and shrinks again. The usable range is therefore ±P/2 samples. Both inputs must already be synchronous to the clock.

Top module: `xor_phase_det`

## Requirements
- R1: While rst_ni is low and after its release, phase_o is 0 and valid_o is 0 until the first XOR rising edge is seen.
- R2: valid_o is high for exactly one cycle, registered one clock after a sample in which a_i XOR b_i is 1 and was 0 in the previous sample. It never stays high for two consecutive cycles.
- R3: The magnitude reported with each strobe equals the number of XOR-high samples in the XOR period just ended. That period starts at the previous XOR rising sample, inclusive, and ends at the current one, exclusive.
- R4: The sign is positive when the most recent lead event was a_i rising while b_i was low. It is negative when the most recent lead event was b_i rising while a_i was low. Simultaneous rises change nothing, and the sign after reset is positive. phase_o is two's complement, CNT_W+1 bits wide.
- R5: For square waves of even period P with 50% duty and a_i leading by d samples, where 1 ≤ d < P/2, every strobe reports +d, and two strobes occur per signal period. With b_i leading by d, every strobe reports −d.
- R6: With a_i leading by d samples where P/2 < d < P, the output wraps and every strobe reports −(P−d).
- R7: If the XOR stays high longer than 2^CNT_W−1 samples, the reported magnitude saturates at 2^CNT_W−1 instead of wrapping.
- R8: Between strobes phase_o holds its value. Identical inputs produce no strobe and leave phase_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Square wave A, synchronous to clk_i |
| b_i | input | 1 | Square wave B, synchronous to clk_i |
| phase_o | output | CNT_W+1 | Signed phase count, two's complement |
| valid_o | output | 1 | One-cycle strobe on each new phase_o |

## Verification
The bench builds the block with CNT_W = 6, which puts the saturation limit of 63 within a short run. It sweeps every even period from 4 to 20 samples and every shift except 0 and P/2. Each shift is checked against ±d or the wrapped −(P−d), computed arithmetically. With the narrow counter, saturation with both signs can be driven directly, followed by a stretch of identical inputs that must leave the output untouched.

// File: rtl/pdet_pkg.sv
package pdet_pkg;
  typedef enum logic {
    LEAD_A = 1'b0,
    LEAD_B = 1'b1
  } lead_e;
endpackage

// File: rtl/pdet_edge.sv
module pdet_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] sig_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sig_q[g] <= 1'b0;
      else         sig_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~sig_q[g];
  end
endmodule

// File: rtl/pdet_lead.sv
module pdet_lead
  import pdet_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  a_lvl_i,
  input  logic  b_lvl_i,
  input  logic  a_rise_i,
  input  logic  b_rise_i,
  output lead_e lead_d_o
);
  lead_e lead_q;

  always_comb begin
    lead_d_o = lead_q;
    if (a_rise_i && !b_lvl_i)      lead_d_o = LEAD_A;
    else if (b_rise_i && !a_lvl_i) lead_d_o = LEAD_B;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lead_q <= LEAD_A;
    else         lead_q <= lead_d_o;
  end
endmodule

// File: rtl/pdet_hcnt.sv
module pdet_hcnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             high_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)   cnt_d = CNT_ONE;
    else if (high_i) cnt_d = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/xor_phase_det.sv
module xor_phase_det
  import pdet_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    a_i,
  input  logic                    b_i,
  output logic signed [CNT_W:0]   phase_o,
  output logic                    valid_o
);
  localparam int unsigned OUT_W = CNT_W + 1;

  logic             x_lvl;
  logic [2:0]       rise;
  logic [CNT_W-1:0] cnt;
  lead_e            lead_d;
  logic signed [OUT_W-1:0] mag;

  assign x_lvl = a_i ^ b_i;

  pdet_edge #(.N(3)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({x_lvl, b_i, a_i}),
    .rise_o (rise)
  );

  pdet_lead u_lead (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_lvl_i  (a_i),
    .b_lvl_i  (b_i),
    .a_rise_i (rise[0]),
    .b_rise_i (rise[1]),
    .lead_d_o (lead_d)
  );

  pdet_hcnt #(.CNT_W(CNT_W)) u_hcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .high_i    (x_lvl),
    .restart_i (rise[2]),
    .cnt_o     (cnt)
  );

  assign mag = signed'({1'b0, cnt});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= rise[2];
      if (rise[2]) phase_o <= (lead_d == LEAD_A) ? mag : -mag;
    end
  end
endmodule

// File: rtl/pdet_chk.sv
module pdet_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  a_i,
  input logic                  b_i,
  input logic signed [CNT_W:0] phase_o,
  input logic                  valid_o
);
  localparam logic [CNT_W:0] MIN_NEG = {1'b1, {CNT_W{1'b0}}};

  logic x_q1, x_q2, a_q1, a_q2, b_q1, b_q2;
  logic signed [CNT_W:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q1 <= 1'b0; x_q2 <= 1'b0;
      a_q1 <= 1'b0; a_q2 <= 1'b0;
      b_q1 <= 1'b0; b_q2 <= 1'b0;
      ph_q <= '0;
    end else begin
      x_q1 <= a_i ^ b_i; x_q2 <= x_q1;
      a_q1 <= a_i;       a_q2 <= a_q1;
      b_q1 <= b_i;       b_q2 <= b_q1;
      ph_q <= phase_o;
    end
  end

  assert_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (x_q1 && !x_q2));

  assert_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> phase_o == ph_q);

  assert_sign_pos_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && a_q1 && !a_q2 && !b_q1) |-> phase_o >= 0);

  assert_sign_neg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && b_q1 && !b_q2 && !a_q1) |-> phase_o <= 0);

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != MIN_NEG);
endmodule

bind xor_phase_det pdet_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .a_i     (a_i),
  .b_i     (b_i),
  .phase_o (phase_o),
  .valid_o (valid_o)
);

// File: tb/tb_xor_phase_det.sv
module tb_xor_phase_det;
  localparam int unsigned CNT_W = 6;
  localparam int SAT = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 1'b0, b = 1'b0;
  logic signed [CNT_W:0] ph;
  logic vld;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xor_phase_det #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .phase_o(ph), .valid_o(vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  endtask

  // period p, a leads b by d samples
  task automatic run_cfg(input int p, input int d);
    int exp_v, nv;
    string req;
    exp_v = (d < p / 2) ? d : -(p - d);
    req = (d < p / 2) ? "R5/R3" : "R6";
    nv = 0;
    for (int c = 0; c < 6 * p; c++) begin
      @(negedge clk);
      if (c >= 3 * p && vld) begin
        nv++;
        chk(int'(ph) == exp_v, req, int'(ph), exp_v);
      end
      a = (c % p) < p / 2;
      b = ((c - d + 10 * p) % p) < p / 2;
    end
    chk(nv == 6, "R2 strobes per window", nv, 6);
  endtask

  task automatic sat_case(input bit a_first);
    int exp_v, seen;
    exp_v = a_first ? SAT : -SAT;
    seen = 0;
    for (int c = 0; c < 3; c++) begin @(negedge clk); a = 0; b = 0; end
    for (int c = 0; c < 100; c++) begin @(negedge clk); a = a_first; b = !a_first; end
    for (int c = 0; c < 3; c++) begin @(negedge clk); a = 1; b = 1; end
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (vld && seen == 0) begin
        seen = 1;
        chk(int'(ph) == exp_v, "R7 saturation", int'(ph), exp_v);
      end
      a = !a_first; b = a_first;
    end
    chk(seen == 1, "R7 strobe seen", seen, 1);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int held, nv;
    repeat (3) @(negedge clk);
    chk(ph == 0, "R1 phase in reset", int'(ph), 0);
    chk(vld == 0, "R1 valid in reset", int'(vld), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ph == 0, "R1 phase after reset", int'(ph), 0);
    chk(vld == 0, "R1 valid after reset", int'(vld), 0);

    for (int p = 4; p <= 20; p += 2)
      for (int d = 1; d < p; d++)
        if (d != p / 2) run_cfg(p, d);

    sat_case(1'b1);
    sat_case(1'b0);

    // R8: identical inputs give no strobe, output held
    @(negedge clk);
    held = int'(ph);
    nv = 0;
    for (int c = 0; c < 40; c++) begin
      a = (c % 6) < 3; b = a;
      @(negedge clk);
      if (c > 0 && vld) nv++;
    end
    chk(nv == 0, "R8 no strobe", nv, 0);
    chk(int'(ph) == held, "R8 held", int'(ph), held);
    finish_run();
  end
endmodule